// File: doc/BRIEF.md
# Atomic-Update GPIO Port Controller

This block controls one general-purpose I/O port of up to sixteen pins. Each pin can be given to a peripheral function or kept as a GPIO pin. A GPIO pin has an output-drive enable, an output value and an input-buffer enable, and the block drives these to the pad through the `pad_*` outputs. Pin inputs pass through a two-stage synchronizer before software can read them.

Software reaches the port through a single-cycle bus. The bus has an address, a write strobe, write data and combinational read data. The output-value register and the direction register each have three addresses: a plain overwrite, a write-one-to-set and a write-one-to-clear. Independent software threads can therefore change separate bits of the same port without a read-modify-write sequence.

After reset every pin is a GPIO pin with its driver and its input buffer both off, so an unused pin can stay unconnected.

Top module: `gpio_port`

## Requirements
- R1: After reset, `pin_func`, `pad_oe` and `pad_ie` are all zero, and every register address reads 0.
- R2: A write to address 4 replaces the whole output-value latch. `pad_out` shows the new latch after the write's clock edge.
- R3: A write to address 5 sets each latch bit whose write bit is 1 and leaves every other bit unchanged.
- R4: A write to address 6 clears each latch bit whose write bit is 1 and leaves every other bit unchanged.
- R5: The direction register has the same three write forms: plain at address 1, set at address 2 and clear at address 3. A 1 means output. Address 1 reads the register back.
- R6: The function register at address 0 holds one bit per pin, where 1 means peripheral. A pin whose bit is 1 has `pad_oe` and `pad_ie` forced to 0. Other pins are unaffected.
- R7: For GPIO pins, `pad_oe` follows the direction bit and `pad_ie` follows the input-enable register. The input-enable register is at address 7 and a 1 means enabled. `pad_out` always equals the output latch.
- R8: A change on `pin_in` shows at address 8 after the second rising clock edge and not after the first.
- R9: A bit at address 8 reads 0 when that pin's input enable is 0 or the pin is in peripheral mode.
- R10: A read of address 4, 5 or 6 returns the output latch for pins whose direction bit is 1. For pins whose direction bit is 0 it returns the address-8 value.
- R11: Addresses 9 to 15 read 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, committed at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_in | input | N_PINS | Raw pin input levels |
| pad_out | output | N_PINS | Output value to the pads |
| pad_oe | output | N_PINS | Output-driver enable per pin |
| pad_ie | output | N_PINS | Input-buffer enable per pin |
| pin_func | output | N_PINS | 1 = pin handed to its peripheral |

## Verification
Directed patterns test the set and clear aliases against a latch value that already holds mixed ones and zeros. Only in that case do "set only the 1 bits" and "overwrite" give different results, and likewise for clear versus overwrite. A mixed function mask checks that the gating acts per pin. Mixed direction and input-enable masks separate the latch path from the synchronized-input path on a data read.

A pin change read one edge and then two edges later separates a two-stage synchronizer from a shorter or longer one. Random write and read sequences over all sixteen addresses, including the unmapped ones, are compared with a bench model. They catch wrong address decoding and cross-talk between registers.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_FUNC     = 4'd0,
        A_DIR      = 4'd1,
        A_DIR_SET  = 4'd2,
        A_DIR_CLR  = 4'd3,
        A_DATA     = 4'd4,
        A_DATA_SET = 4'd5,
        A_DATA_CLR = 4'd6,
        A_INEN     = 4'd7,
        A_PIN      = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_PLAIN = 2'd1,
        WK_SET   = 2'd2,
        WK_CLR   = 2'd3
    } wr_kind_e;

    // Map an address onto the write form for a register with aliases
    // at base, base+1 (set) and base+2 (clear).
    function automatic wr_kind_e decode_kind(input logic [ADDR_W-1:0] a,
                                             input logic we,
                                             input logic [ADDR_W-1:0] base,
                                             input logic has_alias);
        wr_kind_e k;
        k = WK_NONE;
        if (we) begin
            if (a == base)                                   k = WK_PLAIN;
            else if (has_alias && a == base + ADDR_W'(1))    k = WK_SET;
            else if (has_alias && a == base + ADDR_W'(2))    k = WK_CLR;
        end
        return k;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_wreg.sv
module gpio_wreg
    import gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_kind_e     kind,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        unique case (kind)
            WK_PLAIN: nxt = wdata;
            WK_SET:   nxt = q | wdata;
            WK_CLR:   nxt = q & ~wdata;
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_ie,
    output logic [N_PINS-1:0] pin_func
);
    localparam int SYNC_STAGES = 2;

    wr_kind_e          k_func, k_dir, k_data, k_inen;
    logic [N_PINS-1:0] wbits;
    logic [N_PINS-1:0] r_func, r_dir, r_data, r_inen;
    logic [N_PINS-1:0] pin_sync, pin_view, data_view;
    logic [N_PINS-1:0] gpio_mode;

    assign wbits = bus_wdata[N_PINS-1:0];

    always_comb begin
        k_func = decode_kind(bus_addr, bus_we, A_FUNC, 1'b0);
        k_dir  = decode_kind(bus_addr, bus_we, A_DIR,  1'b1);
        k_data = decode_kind(bus_addr, bus_we, A_DATA, 1'b1);
        k_inen = decode_kind(bus_addr, bus_we, A_INEN, 1'b0);
    end

    gpio_wreg #(.W(N_PINS)) u_func (.clk(clk), .rst(rst), .kind(k_func), .wdata(wbits), .q(r_func));
    gpio_wreg #(.W(N_PINS)) u_dir  (.clk(clk), .rst(rst), .kind(k_dir),  .wdata(wbits), .q(r_dir));
    gpio_wreg #(.W(N_PINS)) u_data (.clk(clk), .rst(rst), .kind(k_data), .wdata(wbits), .q(r_data));
    gpio_wreg #(.W(N_PINS)) u_inen (.clk(clk), .rst(rst), .kind(k_inen), .wdata(wbits), .q(r_inen));

    gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
    );

    assign gpio_mode = ~r_func;
    assign pin_view  = pin_sync & r_inen & gpio_mode;
    assign data_view = (r_data & r_dir) | (pin_view & ~r_dir);

    assign pad_out  = r_data;
    assign pad_oe   = r_dir  & gpio_mode;
    assign pad_ie   = r_inen & gpio_mode;
    assign pin_func = r_func;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FUNC:                          bus_rdata[N_PINS-1:0] = r_func;
            A_DIR, A_DIR_SET, A_DIR_CLR:     bus_rdata[N_PINS-1:0] = r_dir;
            A_DATA, A_DATA_SET, A_DATA_CLR:  bus_rdata[N_PINS-1:0] = data_view;
            A_INEN:                          bus_rdata[N_PINS-1:0] = r_inen;
            A_PIN:                           bus_rdata[N_PINS-1:0] = pin_view;
            default:                         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int N_PINS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        bus_addr,
    input logic              bus_we,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] pad_ie,
    input logic [N_PINS-1:0] pin_func
);
    a_r1_reset_drivers_off: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_ie == '0 && pin_func == '0));

    a_r3_set_only_raises: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd5) |=>
            pad_out == ($past(pad_out) | $past(bus_wdata[N_PINS-1:0])));

    a_r4_clear_only_lowers: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd6) |=>
            pad_out == ($past(pad_out) & ~$past(bus_wdata[N_PINS-1:0])));

    a_r2_plain_overwrites: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 4'd4) |=> pad_out == $past(bus_wdata[N_PINS-1:0]));

    a_r11_unmapped_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr > 4'd8) |=>
            ($stable(pad_out) && $stable(pad_oe) && $stable(pad_ie) && $stable(pin_func)));

    a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > 4'd8) |-> bus_rdata == '0);

    a_r6_peripheral_pins_released: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_ie) & pin_func) == '0);
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_ie(pad_ie), .pin_func(pin_func)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int N = 16;

    logic          clk = 0;
    logic          rst = 1;
    logic [3:0]    bus_addr = '0;
    logic          bus_we = 0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_ie, pin_func;

    int errors = 0;
    int checks = 0;

    // Bench model of the register state
    logic [N-1:0] m_func, m_dir, m_data, m_inen;
    logic [N-1:0] p1, p2;

    always #4 clk = ~clk;

    gpio_port #(.N_PINS(N)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie), .pin_func(pin_func)
    );

    // Two-edge delay model of the pin input (R8)
    always @(posedge clk) begin
        if (rst) begin p1 <= '0; p2 <= '0; end
        else     begin p1 <= pin_in; p2 <= p1; end
    end

    function automatic logic [15:0] exp_pin();
        return p2 & m_inen & ~m_func;
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0:             return m_func;
            4'd1, 4'd2, 4'd3: return m_dir;
            4'd4, 4'd5, 4'd6: return (m_data & m_dir) | (exp_pin() & ~m_dir);
            4'd7:             return m_inen;
            4'd8:             return exp_pin();
            default:          return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk);
        case (a)
            4'd0: m_func = d;
            4'd1: m_dir  = d;
            4'd2: m_dir  = m_dir | d;
            4'd3: m_dir  = m_dir & ~d;
            4'd4: m_data = d;
            4'd5: m_data = m_data | d;
            4'd6: m_data = m_data & ~d;
            4'd7: m_inen = d;
            default: ;
        endcase
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        bus_addr = a; bus_we = 0;
        #1;
        v = bus_rdata;
    endtask

    task automatic chk_pads(input string tag);
        chk({tag, " pad_out"},  pad_out,  m_data);
        chk({tag, " pad_oe"},   pad_oe,   m_dir & ~m_func);
        chk({tag, " pad_ie"},   pad_ie,   m_inen & ~m_func);
        chk({tag, " pin_func"}, pin_func, m_func);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] old_pins;
        void'($urandom(32'd1234));
        m_func = '0; m_dir = '0; m_data = '0; m_inen = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);

        // R1 reset state
        chk_pads("R1 reset");
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v); chk("R1 reset read", v, 16'h0);
        end

        // R2 / R3 / R4 on a mixed latch, all pins outputs
        wr(4'd1, 16'hFFFF);
        wr(4'd4, 16'hA5C3);
        chk("R2 plain data", pad_out, 16'hA5C3);
        wr(4'd5, 16'h0F0F);
        chk("R3 set data", pad_out, 16'hAFCF);
        wr(4'd6, 16'h8181);
        chk("R4 clear data", pad_out, 16'h2E4E);
        rd(4'd4, v); chk("R10 read outputs", v, 16'h2E4E);

        // R5 direction aliases
        wr(4'd1, 16'h3C3C);
        wr(4'd2, 16'h0003);
        rd(4'd1, v); chk("R5 dir set", v, 16'h3C3F);
        wr(4'd3, 16'h0C01);
        rd(4'd1, v); chk("R5 dir clear", v, 16'h303E);
        chk("R7 pad_oe follows dir", pad_oe, 16'h303E);

        // R6 per-pin function gating
        wr(4'd7, 16'hFFFF);
        wr(4'd0, 16'h0030);
        chk("R6 oe gated", pad_oe, 16'h300E);
        chk("R6 ie gated", pad_ie, 16'hFFCF);
        chk_pads("R7 pads");

        // R8 latency and R9 masking
        wr(4'd0, 16'h0000);
        wr(4'd7, 16'h00FF);
        old_pins = 16'h0000;
        pin_in = 16'h5AA5;
        rd(4'd8, v); chk("R8 before edge", v, old_pins);
        @(negedge clk);
        rd(4'd8, v); chk("R8 after one edge", v, old_pins);
        @(negedge clk);
        rd(4'd8, v); chk("R8/R9 after two edges", v, 16'h00A5);
        wr(4'd0, 16'h0001);
        rd(4'd8, v); chk("R9 peripheral reads 0", v, 16'h00A4);
        wr(4'd0, 16'h0000);

        // R10 mixed read
        rd(4'd5, v); chk("R10 mixed read", v, exp_read(4'd5));

        // R11 unmapped
        wr(4'd12, 16'hFFFF);
        chk_pads("R11 unmapped write");
        rd(4'd12, v); chk("R11 unmapped read", v, 16'h0);

        // Random phase
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) pin_in = 16'($urandom);
            wr(4'($urandom_range(0, 15)), 16'($urandom));
            begin
                logic [3:0] ra;
                ra = 4'($urandom_range(0, 15));
                rd(ra, v);
                chk("R2-R11 random read", v, exp_read(ra));
            end
            if (i % 16 == 0) chk_pads("R7 random pads");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule